// File: doc/BRIEF.md
# MESI Snooping Cache Coherence Controller

This block keeps one private, direct-mapped cache coherent with its peers on a shared snooping bus. Each cache set holds one line of one data word, a tag and a four-state coherence tag: Invalid, Shared, Exclusive or Modified. The controller serves processor loads and stores. When it has to, it masters the bus to fetch a line, to fetch a line with intent to modify, to broadcast a dataless invalidate, or to write a dirty line back.

In parallel the controller watches the transactions that other caches place on the bus. For a snooped read it reports that it holds a copy and may source the data cache-to-cache, which lets memory skip its access. For a snooped read-for-ownership of a dirty line it blocks the requester, writes the line back on its own bus turn and drops the copy. The requester then retries. Every bus transaction completes in the cycle it is granted, and the response signals (data, shared, abort) are valid in that same cycle.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: A processor read that hits a valid line (tag equal, state M, E or S) raises `cpu_rsp_o` with the cached word in the cycle after acceptance, issues no bus request and leaves the state unchanged.
- R2: A read miss issues `bus_cmd_o` = 1 (READ). The bus command codes are 1 READ, 2 RWITM, 3 INV and 4 WB, and the set index is the low address bits. On the granted cycle the line installs as E if `bus_shared_i` is low and as S if it is high, and `bus_rdata_i` is returned to the processor.
- R3: A snooped READ (`snp_cmd_i` = 1) that hits an E line asserts `snp_shared_o` and `snp_supply_o` with the word on `snp_data_o`, keeps `snp_dirty_o` low, and moves the line to S.
- R4: A snooped READ that hits an S line asserts `snp_shared_o`. It sources data (`snp_supply_o`) only when `snp_sel_i` marks this cache as the chosen supplier. The line stays S.
- R5: A snooped READ that hits an M line sources the data with `snp_dirty_o` high, so that memory captures the copy, and moves the line to S.
- R6: A write hit in M, or a write hit in E, updates the word with no bus transaction. An E line becomes M.
- R7: A write hit in S issues a dataless INV (3) and, when granted, makes the line M with the new word. If a snoop invalidates the line before the grant, the controller issues RWITM (2) instead.
- R8: A write miss issues RWITM and installs the line as M holding the written word. A snooped RWITM (2) or INV (3) that hits an E or S line moves it to I without aborting.
- R9: A snooped RWITM that hits an M line asserts `snp_abort_o`. The controller then requests the bus with WB (4) carrying that address and word, and the line is I afterwards.
- R10: When `bus_abort_i` is high on a granted READ or RWITM of the controller, nothing is installed and the same command is requested again.
- R11: `cpu_ready_o` is low in every cycle in which `snp_valid_i` is high and while a processor miss or upgrade is in progress.
- R12: A miss whose victim line is M first writes the victim back with WB at its own address, then fetches. A miss whose victim is E or S evicts it silently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_valid_i | input | 1 | Processor request valid |
| cpu_write_i | input | 1 | Request is a store |
| cpu_addr_i | input | ADDR_W | Request word address |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_ready_o | output | 1 | Request accepted this cycle when valid |
| cpu_rsp_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Load data (written word for stores) |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus granted; the transaction completes this cycle |
| bus_cmd_o | output | 3 | Bus command code |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_rdata_i | input | DATA_W | Fill data from memory or a peer cache |
| bus_shared_i | input | 1 | Wired-OR: another cache holds the line |
| bus_abort_i | input | 1 | A peer blocked the transaction; retry |
| snp_valid_i | input | 1 | Peer transaction visible for snooping |
| snp_cmd_i | input | 3 | Snooped command code |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_sel_i | input | 1 | This cache is the chosen supplier among sharers |
| snp_shared_o | output | 1 | Copy held (snooped READ) |
| snp_supply_o | output | 1 | Data sourced on snp_data_o |
| snp_data_o | output | DATA_W | Sourced word |
| snp_dirty_o | output | 1 | Sourced word is dirty; memory must capture it |
| snp_abort_o | output | 1 | Snooped RWITM blocked |

## Verification
The hardest situation to reach is the lost upgrade: a store that hits a Shared line waits for the bus, and a peer's invalidate of the same line arrives first, so the pending INV has to turn into an RWITM. The bench creates it by loading a line with the shared signal high. It then issues a store and, while the INV request is visible but the grant is held back, drives a snooped invalidate to the same address. Only after that does it grant and check the command. A similar held-back grant sequence checks that a blocked write-back takes the bus before any fill, and that an aborted fill is requested again.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_t;
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0, CMD_READ = 3'd1, CMD_RWITM = 3'd2, CMD_INV = 3'd3, CMD_WB = 3'd4
  } bus_cmd_t;
  typedef enum logic [1:0] {F_IDLE, F_EVICT, F_FILL, F_UPG} req_fsm_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  a_idx_i,
  output mesi_t             a_st_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [DATA_W-1:0] a_data_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output mesi_t             b_st_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output logic [DATA_W-1:0] b_data_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  mesi_t             wst_i,
  input  logic [TAG_W-1:0]  wtag_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              swe_i,
  input  logic [IDX_W-1:0]  sidx_i,
  input  mesi_t             sst_i
);
  logic [SETS-1:0][1:0]        st_v;
  logic [SETS-1:0][TAG_W-1:0]  tag_v;
  logic [SETS-1:0][DATA_W-1:0] data_v;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    mesi_t             st_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] data_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_r   <= ST_I;
        tag_r  <= '0;
        data_r <= '0;
      end else if (we_i && widx_i == IDX_W'(s)) begin
        st_r   <= wst_i;
        tag_r  <= wtag_i;
        data_r <= wdata_i;
      end else if (swe_i && sidx_i == IDX_W'(s)) begin
        st_r   <= sst_i;
      end
    end
    assign st_v[s]   = st_r;
    assign tag_v[s]  = tag_r;
    assign data_v[s] = data_r;
  end

  assign a_st_o   = mesi_t'(st_v[a_idx_i]);
  assign a_tag_o  = tag_v[a_idx_i];
  assign a_data_o = data_v[a_idx_i];
  assign b_st_o   = mesi_t'(st_v[b_idx_i]);
  assign b_tag_o  = tag_v[b_idx_i];
  assign b_data_o = data_v[b_idx_i];

  // local fill/update and snoop update never land in the same cycle
  AST_ONE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && swe_i)); // R11
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snp_valid_i,
  input  bus_cmd_t         snp_cmd_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  logic             snp_sel_i,
  input  mesi_t            line_st_i,
  input  logic [TAG_W-1:0] line_tag_i,
  input  logic             wb_busy_i,
  output logic             shared_o,
  output logic             supply_o,
  output logic             dirty_o,
  output logic             abort_o,
  output logic             upd_en_o,
  output mesi_t            upd_st_o,
  output logic             capture_o
);
  logic hit;
  assign hit = snp_valid_i && line_st_i != ST_I && line_tag_i == snp_tag_i;

  always_comb begin
    shared_o  = 1'b0;
    supply_o  = 1'b0;
    dirty_o   = 1'b0;
    abort_o   = 1'b0;
    upd_en_o  = 1'b0;
    upd_st_o  = line_st_i;
    capture_o = 1'b0;
    if (hit) begin
      unique case (snp_cmd_i)
        CMD_READ: begin
          shared_o = 1'b1;
          supply_o = (line_st_i != ST_S) || snp_sel_i;
          dirty_o  = line_st_i == ST_M;
          if (line_st_i != ST_S) begin
            upd_en_o = 1'b1;
            upd_st_o = ST_S;
          end
        end
        CMD_RWITM: begin
          if (line_st_i == ST_M) begin
            abort_o = 1'b1;
            // with the buffer full, block only; the requester keeps retrying
            if (!wb_busy_i) begin
              capture_o = 1'b1;
              upd_en_o  = 1'b1;
              upd_st_o  = ST_I;
            end
          end else begin
            upd_en_o = 1'b1;
            upd_st_o = ST_I;
          end
        end
        CMD_INV: begin
          upd_en_o = 1'b1;
          upd_st_o = ST_I;
        end
        default: ;
      endcase
    end
  end

  AST_INV_ON_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && snp_cmd_i == CMD_INV) |-> line_st_i == ST_S); // R8
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  input  logic              cpu_write_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              cpu_rsp_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  input  mesi_t             lk_st_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [DATA_W-1:0] lk_data_i,
  output logic              we_o,
  output logic [IDX_W-1:0]  widx_o,
  output mesi_t             wst_o,
  output logic [TAG_W-1:0]  wtag_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output bus_cmd_t          bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_shared_i,
  input  logic              bus_abort_i,
  input  logic              snp_valid_i,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic              wb_busy_o
);
  req_fsm_t          st_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              swb_q;
  logic [ADDR_W-1:0] swb_addr_q;
  logic [DATA_W-1:0] swb_data_q;
  logic              rsp_q;
  logic [DATA_W-1:0] rdata_q;

  logic [TAG_W-1:0] cpu_tag, req_tag;
  logic [IDX_W-1:0] req_idx;
  logic             accept, cpu_hit, own_gnt, fsm_need;
  bus_cmd_t         fsm_cmd;
  logic [ADDR_W-1:0] fsm_addr;
  logic [DATA_W-1:0] fsm_wd;

  assign cpu_tag  = cpu_addr_i[ADDR_W-1:IDX_W];
  assign req_tag  = addr_q[ADDR_W-1:IDX_W];
  assign req_idx  = addr_q[IDX_W-1:0];
  assign lk_idx_o = (st_q == F_IDLE) ? cpu_addr_i[IDX_W-1:0] : req_idx;

  assign cpu_ready_o = (st_q == F_IDLE) && !snp_valid_i;
  assign accept      = cpu_valid_i && cpu_ready_o;
  assign cpu_hit     = lk_st_i != ST_I && lk_tag_i == cpu_tag;

  // bus command is re-evaluated each cycle against the current line state
  always_comb begin
    fsm_need = 1'b0;
    fsm_cmd  = CMD_NONE;
    fsm_addr = addr_q;
    fsm_wd   = wdata_q;
    unique case (st_q)
      F_EVICT: if (lk_st_i == ST_M) begin
        fsm_need = 1'b1;
        fsm_cmd  = CMD_WB;
        fsm_addr = {lk_tag_i, req_idx};
        fsm_wd   = lk_data_i;
      end
      F_FILL: begin
        fsm_need = 1'b1;
        fsm_cmd  = wr_q ? CMD_RWITM : CMD_READ;
      end
      F_UPG: begin
        fsm_need = 1'b1;
        fsm_cmd  = (lk_st_i == ST_S && lk_tag_i == req_tag) ? CMD_INV : CMD_RWITM;
      end
      default: ;
    endcase
  end

  assign bus_req_o   = swb_q || fsm_need;
  assign bus_cmd_o   = swb_q ? CMD_WB : fsm_cmd;
  assign bus_addr_o  = swb_q ? swb_addr_q : fsm_addr;
  assign bus_wdata_o = swb_q ? swb_data_q : fsm_wd;
  assign own_gnt     = bus_gnt_i && !swb_q && fsm_need;
  assign wb_busy_o   = swb_q;

  always_comb begin
    we_o    = 1'b0;
    widx_o  = req_idx;
    wst_o   = ST_M;
    wtag_o  = req_tag;
    wdata_o = wdata_q;
    unique case (st_q)
      F_IDLE: if (accept && cpu_write_i && cpu_hit && lk_st_i != ST_S) begin
        we_o    = 1'b1;
        widx_o  = cpu_addr_i[IDX_W-1:0];
        wtag_o  = cpu_tag;
        wdata_o = cpu_wdata_i;
      end
      F_EVICT: if (own_gnt) begin
        we_o    = 1'b1;
        wst_o   = ST_I;
        wtag_o  = lk_tag_i;
        wdata_o = lk_data_i;
      end
      F_FILL: if (own_gnt && !bus_abort_i) begin
        we_o = 1'b1;
        if (!wr_q) begin
          wst_o   = bus_shared_i ? ST_S : ST_E;
          wdata_o = bus_rdata_i;
        end
      end
      F_UPG: we_o = own_gnt && !bus_abort_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= F_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rsp_q <= 1'b0;
      unique case (st_q)
        F_IDLE: if (accept) begin
          wr_q    <= cpu_write_i;
          addr_q  <= cpu_addr_i;
          wdata_q <= cpu_wdata_i;
          if (cpu_hit && !(cpu_write_i && lk_st_i == ST_S)) begin
            rsp_q   <= 1'b1;
            rdata_q <= cpu_write_i ? cpu_wdata_i : lk_data_i;
          end else if (cpu_hit) begin
            st_q <= F_UPG;
          end else begin
            st_q <= (lk_st_i == ST_M) ? F_EVICT : F_FILL;
          end
        end
        F_EVICT: if (lk_st_i != ST_M || own_gnt) st_q <= F_FILL;
        F_FILL, F_UPG: if (own_gnt && !bus_abort_i) begin
          st_q    <= F_IDLE;
          rsp_q   <= 1'b1;
          rdata_q <= wr_q ? wdata_q : bus_rdata_i;
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swb_q      <= 1'b0;
      swb_addr_q <= '0;
      swb_data_q <= '0;
    end else if (cap_i) begin
      swb_q      <= 1'b1;
      swb_addr_q <= cap_addr_i;
      swb_data_q <= cap_data_i;
    end else if (swb_q && bus_gnt_i) begin
      swb_q <= 1'b0;
    end
  end

  assign cpu_rsp_o   = rsp_q;
  assign cpu_rdata_o = rdata_q;

  AST_HIT_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !cpu_write_i && cpu_hit) |=> cpu_rsp_o); // R1
  AST_SILENT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cpu_write_i && cpu_hit && (lk_st_i == ST_M || lk_st_i == ST_E))
      |=> !(bus_req_o && bus_cmd_o != CMD_WB)); // R6
  AST_RETRY_AFTER_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_gnt && bus_abort_i && (fsm_cmd == CMD_READ || fsm_cmd == CMD_RWITM))
      |=> bus_req_o); // R10
endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SETS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  input  logic              cpu_write_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              cpu_rsp_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_shared_i,
  input  logic              bus_abort_i,
  input  logic              snp_valid_i,
  input  logic [2:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic              snp_sel_i,
  output logic              snp_shared_o,
  output logic              snp_supply_o,
  output logic [DATA_W-1:0] snp_data_o,
  output logic              snp_dirty_o,
  output logic              snp_abort_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx, widx;
  mesi_t             lk_st, b_st, wst, sst;
  logic [TAG_W-1:0]  lk_tag, b_tag, wtag;
  logic [DATA_W-1:0] lk_data, b_data, wdata;
  logic              we, swe, capture, wb_busy;
  bus_cmd_t          bus_cmd;

  mesi_line_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .a_idx_i(lk_idx), .a_st_o(lk_st), .a_tag_o(lk_tag), .a_data_o(lk_data),
    .b_idx_i(snp_addr_i[IDX_W-1:0]), .b_st_o(b_st), .b_tag_o(b_tag), .b_data_o(b_data),
    .we_i(we), .widx_i(widx), .wst_i(wst), .wtag_i(wtag), .wdata_i(wdata),
    .swe_i(swe), .sidx_i(snp_addr_i[IDX_W-1:0]), .sst_i(sst)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .clk_i, .rst_ni,
    .snp_valid_i, .snp_cmd_i(bus_cmd_t'(snp_cmd_i)), .snp_tag_i(snp_addr_i[ADDR_W-1:IDX_W]),
    .snp_sel_i, .line_st_i(b_st), .line_tag_i(b_tag), .wb_busy_i(wb_busy),
    .shared_o(snp_shared_o), .supply_o(snp_supply_o), .dirty_o(snp_dirty_o),
    .abort_o(snp_abort_o), .upd_en_o(swe), .upd_st_o(sst), .capture_o(capture)
  );

  mesi_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_fsm (
    .clk_i, .rst_ni,
    .cpu_valid_i, .cpu_write_i, .cpu_addr_i, .cpu_wdata_i,
    .cpu_ready_o, .cpu_rsp_o, .cpu_rdata_o,
    .lk_idx_o(lk_idx), .lk_st_i(lk_st), .lk_tag_i(lk_tag), .lk_data_i(lk_data),
    .we_o(we), .widx_o(widx), .wst_o(wst), .wtag_o(wtag), .wdata_o(wdata),
    .bus_req_o, .bus_gnt_i, .bus_cmd_o(bus_cmd), .bus_addr_o, .bus_wdata_o,
    .bus_rdata_i, .bus_shared_i, .bus_abort_i,
    .snp_valid_i, .cap_i(capture), .cap_addr_i(snp_addr_i), .cap_data_i(b_data),
    .wb_busy_o(wb_busy)
  );

  assign bus_cmd_o  = bus_cmd;
  assign snp_data_o = b_data;

  AST_BLOCK_THEN_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_abort_o && !wb_busy) |=> (bus_req_o && bus_cmd_o == 3'd4)); // R9
endmodule

// File: tb/mesi_cache_ctrl_test.sv
`timescale 1ns/1ps
module mesi_cache_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_valid = 0, cpu_write = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0;
  logic       cpu_ready, cpu_rsp;
  logic [7:0] cpu_rdata;
  logic       bus_req, bus_gnt = 0, bus_shared = 0, bus_abort = 0;
  logic [2:0] bus_cmd;
  logic [7:0] bus_addr, bus_wdata, bus_rdata = 0;
  logic       snp_valid = 0, snp_sel = 0;
  logic [2:0] snp_cmd = 0;
  logic [7:0] snp_addr = 0;
  logic       snp_shared, snp_supply, snp_dirty, snp_abort;
  logic [7:0] snp_data;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mesi_cache_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_valid_i(cpu_valid), .cpu_write_i(cpu_write), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_ready_o(cpu_ready), .cpu_rsp_o(cpu_rsp),
    .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_shared_i(bus_shared),
    .bus_abort_i(bus_abort),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr), .snp_sel_i(snp_sel),
    .snp_shared_o(snp_shared), .snp_supply_o(snp_supply), .snp_data_o(snp_data),
    .snp_dirty_o(snp_dirty), .snp_abort_o(snp_abort)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive a request; returns at the negedge after acceptance
  task automatic cpu_op(input bit wr, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_valid = 1; cpu_write = wr; cpu_addr = a; cpu_wdata = d;
    while (!cpu_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 0; cpu_write = 0;
  endtask

  task automatic get_rsp(input string req, input logic [7:0] exp, input int max_wait);
    bit seen = 0;
    for (int i = 0; i <= max_wait; i++) begin
      if (cpu_rsp) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, req, "response pulse", 32'(seen), 1);
    if (seen) chk(cpu_rdata == exp, req, "response data", cpu_rdata, exp);
  endtask

  task automatic bus_serve(input string req, input logic [2:0] cmd, input logic [7:0] a,
                           input logic [7:0] rd, input bit sh, input bit ab,
                           input logic [7:0] exp_wd);
    bit seen = 0;
    for (int i = 0; i < 8; i++) begin
      if (bus_req) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, req, "bus request", 32'(seen), 1);
    chk(bus_cmd == cmd, req, "bus command", bus_cmd, cmd);
    chk(bus_addr == a, req, "bus address", bus_addr, a);
    if (cmd == 3'd4) chk(bus_wdata == exp_wd, req, "write-back data", bus_wdata, exp_wd);
    bus_gnt = 1; bus_rdata = rd; bus_shared = sh; bus_abort = ab;
    @(posedge clk);
    @(negedge clk);
    bus_gnt = 0; bus_shared = 0; bus_abort = 0;
  endtask

  task automatic snoop(input string req, input logic [2:0] cmd, input logic [7:0] a,
                       input bit sel, input bit e_sh, input bit e_sup, input bit e_dirty,
                       input bit e_ab, input logic [7:0] e_data);
    snp_valid = 1; snp_cmd = cmd; snp_addr = a; snp_sel = sel;
    #1;
    chk(snp_shared == e_sh, req, "snoop shared", 32'(snp_shared), 32'(e_sh));
    chk(snp_supply == e_sup, req, "snoop supply", 32'(snp_supply), 32'(e_sup));
    chk(snp_dirty == e_dirty, req, "snoop dirty", 32'(snp_dirty), 32'(e_dirty));
    chk(snp_abort == e_ab, req, "snoop abort", 32'(snp_abort), 32'(e_ab));
    if (e_sup) chk(snp_data == e_data, req, "snoop data", snp_data, e_data);
    chk(!cpu_ready, "R11", "ready during snoop", 32'(cpu_ready), 0);
    @(posedge clk);
    @(negedge clk);
    snp_valid = 0; snp_sel = 0;
  endtask

  task automatic t_reset();
    chk(cpu_ready && !bus_req && !cpu_rsp, "R11", "reset outputs",
        {29'd0, cpu_ready, bus_req, cpu_rsp}, 3'b100);
    snoop("R2", 3'd1, 8'h10, 0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic t_read_exclusive();
    cpu_op(0, 8'h04, 8'h00);
    bus_serve("R2", 3'd1, 8'h04, 8'h5A, 0, 0, 8'h00);
    get_rsp("R2", 8'h5A, 0);
    cpu_op(0, 8'h04, 8'h00);
    get_rsp("R1", 8'h5A, 0);
    chk(!bus_req, "R1", "no bus on read hit", 32'(bus_req), 0);
    snoop("R3", 3'd1, 8'h04, 0, 1, 1, 0, 0, 8'h5A);
  endtask

  task automatic t_upgrade_and_share();
    cpu_op(1, 8'h04, 8'h77);
    bus_serve("R7", 3'd3, 8'h04, 8'h00, 0, 0, 8'h00);
    get_rsp("R7", 8'h77, 0);
    snoop("R5", 3'd1, 8'h04, 0, 1, 1, 1, 0, 8'h77);
    snoop("R4", 3'd1, 8'h04, 0, 1, 0, 0, 0, 8'h00);
    snoop("R4", 3'd1, 8'h04, 1, 1, 1, 0, 0, 8'h77);
  endtask

  task automatic t_read_shared();
    cpu_op(0, 8'h05, 8'h00);
    bus_serve("R2", 3'd1, 8'h05, 8'h33, 1, 0, 8'h00);
    get_rsp("R2", 8'h33, 0);
    cpu_op(1, 8'h05, 8'h3C);
    bus_serve("R2", 3'd3, 8'h05, 8'h00, 0, 0, 8'h00);
    get_rsp("R7", 8'h3C, 0);
  endtask

  task automatic t_silent_write();
    cpu_op(0, 8'h06, 8'h00);
    bus_serve("R2", 3'd1, 8'h06, 8'h11, 0, 0, 8'h00);
    get_rsp("R2", 8'h11, 0);
    cpu_op(1, 8'h06, 8'h22);
    get_rsp("R6", 8'h22, 0);
    chk(!bus_req, "R6", "no bus on E write", 32'(bus_req), 0);
    snoop("R6", 3'd1, 8'h06, 0, 1, 1, 1, 0, 8'h22);
    snoop("R8", 3'd3, 8'h06, 0, 0, 0, 0, 0, 8'h00);
    snoop("R8", 3'd1, 8'h06, 0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic t_write_miss_and_block();
    cpu_op(1, 8'h07, 8'h44);
    bus_serve("R8", 3'd2, 8'h07, 8'h99, 0, 0, 8'h00);
    get_rsp("R8", 8'h44, 0);
    cpu_op(1, 8'h07, 8'h45);
    get_rsp("R6", 8'h45, 0);
    chk(!bus_req, "R6", "no bus on M write", 32'(bus_req), 0);
    snoop("R9", 3'd2, 8'h07, 0, 0, 0, 0, 1, 8'h00);
    bus_serve("R9", 3'd4, 8'h07, 8'h00, 0, 0, 8'h45);
    snoop("R9", 3'd1, 8'h07, 0, 0, 0, 0, 0, 8'h00);
    snoop("R8", 3'd2, 8'h04, 0, 0, 0, 0, 0, 8'h00);
    snoop("R8", 3'd1, 8'h04, 0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic t_evict_and_retry();
    cpu_op(0, 8'h15, 8'h00);
    bus_serve("R12", 3'd4, 8'h05, 8'h00, 0, 0, 8'h3C);
    bus_serve("R10", 3'd1, 8'h15, 8'hEE, 0, 1, 8'h00);
    chk(!cpu_rsp, "R10", "no response on abort", 32'(cpu_rsp), 0);
    bus_serve("R10", 3'd1, 8'h15, 8'h66, 0, 0, 8'h00);
    get_rsp("R10", 8'h66, 0);
    cpu_op(0, 8'h25, 8'h00);
    bus_serve("R12", 3'd1, 8'h25, 8'h21, 0, 0, 8'h00);
    get_rsp("R12", 8'h21, 0);
    snoop("R8", 3'd2, 8'h25, 0, 0, 0, 0, 0, 8'h00);
    snoop("R8", 3'd1, 8'h25, 0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic t_lost_upgrade();
    cpu_op(0, 8'h08, 8'h00);
    bus_serve("R2", 3'd1, 8'h08, 8'h70, 1, 0, 8'h00);
    get_rsp("R2", 8'h70, 0);
    cpu_op(1, 8'h08, 8'h55);
    chk(bus_req && bus_cmd == 3'd3, "R7", "INV pending", {29'd0, bus_cmd}, 3);
    snoop("R7", 3'd3, 8'h08, 0, 0, 0, 0, 0, 8'h00);
    bus_serve("R7", 3'd2, 8'h08, 8'h70, 0, 0, 8'h00);
    get_rsp("R7", 8'h55, 0);
    snoop("R7", 3'd1, 8'h08, 0, 1, 1, 1, 0, 8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_exclusive();
    t_upgrade_and_share();
    t_read_shared();
    t_silent_write();
    t_write_miss_and_block();
    t_evict_and_retry();
    t_lost_upgrade();
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule